// File: doc/BRIEF.md
# Posted Register Write Tracker

This block sits between a fast bus and a small set of registers kept in a slow, always-on domain. A bus write to one of five targets is not carried out at once. The block captures it in a per-target buffer, marks that target as pending, and later hands the transaction across to the slow domain over a request/acknowledge handshake. The five targets are a status-clear register, two count words and two alarm words.

Software reads a status word to find out whether a target can take another write. A data target (count or alarm) takes one posting at a time. A write to it while its previous posting is still outstanding is refused and flagged for one cycle. The status-clear target never refuses a write. Each clear mask is ORed into the outstanding clear transaction, so no earlier clear is lost. A clear mask that arrives while an earlier mask is already in flight starts a fresh transaction, and that transaction follows the first one. Only one transfer is in flight at a time. Waiting targets are served in a fixed order.

Top module: `posted_write_tracker`

## Requirements
- R1: `pend_status` carries one pending bit per target: bit 8 status-clear, bit 9 count word 0, bit 10 count word 1, bit 11 alarm word 0, bit 12 alarm word 1. Bits 15:13 and 7:0 always read 0.
- R2: A write to a data target (`wr_sel` 1 = count 0, 2 = count 1, 3 = alarm 0, 4 = alarm 1) whose pending bit is 0 is accepted. It sets that pending bit, and the later transfer carries exactly the written data.
- R3: A write to a data target whose pending bit is 1 is refused. `wr_refused` is 1 in the single cycle after that write, and the buffered data of the earlier write is the data that is transferred.
- R4: A data target's pending bit reads 0 from the cycle after the one in which `xfer_ack` is seen with `xfer_req` high. A write to that target is accepted from then on.
- R5: Writes to the status-clear target (`wr_sel` 0) are never refused. The 1-bits of all clear masks written before a clear transfer starts are ORed into that one transfer.
- R6: A clear mask written while a clear transfer is in flight, including in the very cycle of its acknowledge, keeps bit 8 at 1 and is sent as a separate, later transfer.
- R7: When several targets wait, transfers start in the order status-clear, count 0, count 1, alarm 0, alarm 1. `xfer_sel` uses the same codes as `wr_sel`.
- R8: `xfer_req` stays high with stable `xfer_sel` and `xfer_data` until `xfer_ack` is seen. It drops in the next cycle, and at most one transfer is in flight.
- R9: A clear write with an all-zero mask, and any write with `wr_sel` 5 to 7, changes no pending bit, raises no refusal and starts no transfer.
- R10: After reset, `pend_status`, `xfer_req` and `wr_refused` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_sel | input | 3 | Target code of the write |
| wr_data | input | DW | Write data, or clear mask for target 0 |
| wr_refused | output | 1 | One-cycle flag for a refused data write |
| pend_status | output | 16 | Read-only pending status word |
| xfer_req | output | 1 | Transfer request to the slow domain |
| xfer_sel | output | 3 | Target code of the transfer in flight |
| xfer_data | output | DW | Data or clear mask of the transfer in flight |
| xfer_ack | input | 1 | Acknowledge from the slow domain |

## Verification
The bench stalls the acknowledge so that every target is pending at once. Then it releases the acknowledge and checks the order of the transfers. A design with a wrong priority would send a count or alarm word before the merged clear mask. A second data write to a busy target must be refused. A design that overwrote the buffer would transfer the newer value, and one that kept no refusal pulse would leave the flag low. Clear masks are written both before a clear transfer starts and while one is in flight, and one mask lands in the acknowledge cycle itself. A design that merged into the in-flight mask, or cleared the pending bit at the acknowledge without looking at new input, would lose that mask or send it inside the earlier transfer.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int NUM_TGT  = 5;
  localparam int SEL_W    = 3;
  localparam int STAT_W   = 16;
  localparam int STAT_LSB = 8;

  // Target codes; the numeric order is also the service priority.
  typedef enum logic [SEL_W-1:0] {
    TGT_SCLR = 3'd0,
    TGT_CNT0 = 3'd1,
    TGT_CNT1 = 3'd2,
    TGT_ALM0 = 3'd3,
    TGT_ALM1 = 3'd4
  } tgt_e;
endpackage

// File: rtl/pwt_intake.sv
// Per-target posting buffers and pending state.
module pwt_intake
  import pwt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DW-1:0]                wr_data,
  input  logic                         launch_go,
  input  logic [SEL_W-1:0]             launch_sel,
  input  logic                         done_go,
  input  logic [SEL_W-1:0]             done_sel,
  output logic [NUM_TGT-1:0]           pend,
  output logic [NUM_TGT-1:0]           ready,
  output logic [NUM_TGT-1:0][DW-1:0]   word,
  output logic                         refused
);

  // Status-clear slot: accumulating mask plus an in-flight marker.
  logic [DW-1:0] clr_buf;
  logic          clr_fly;
  logic [DW-1:0] clr_in;
  logic          clr_launch;
  logic          clr_done;

  assign clr_in     = (wr_en && wr_sel == SEL_W'(TGT_SCLR)) ? wr_data : '0;
  assign clr_launch = launch_go && launch_sel == SEL_W'(TGT_SCLR);
  assign clr_done   = done_go && done_sel == SEL_W'(TGT_SCLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_buf <= '0;
      clr_fly <= 1'b0;
    end else begin
      // The launched mask leaves the buffer; later clears start a new one.
      clr_buf <= clr_launch ? '0 : (clr_buf | clr_in);
      if (clr_launch)
        clr_fly <= 1'b1;
      else if (clr_done)
        clr_fly <= 1'b0;
    end
  end

  assign pend[0]  = clr_fly | (|clr_buf);
  assign ready[0] = |clr_buf;
  assign word[0]  = clr_buf | clr_in;

  // Data slots: one posting each, refused while outstanding.
  for (genvar g = 1; g < NUM_TGT; g++) begin : g_data
    logic          hit;
    logic          pend_q;
    logic [DW-1:0] buf_q;

    assign hit = wr_en && wr_sel == SEL_W'(g);

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        buf_q  <= '0;
      end else if (hit && !pend_q) begin
        pend_q <= 1'b1;
        buf_q  <= wr_data;
      end else if (done_go && done_sel == SEL_W'(g)) begin
        pend_q <= 1'b0;
      end
    end

    assign pend[g]  = pend_q;
    assign ready[g] = pend_q;
    assign word[g]  = buf_q;
  end

  logic refuse_now;
  always_comb begin
    refuse_now = 1'b0;
    for (int i = 1; i < NUM_TGT; i++)
      if (wr_en && wr_sel == SEL_W'(i) && pend[i])
        refuse_now = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) refused <= 1'b0;
    else     refused <= refuse_now;
  end

endmodule

// File: rtl/pwt_arbiter.sv
// Fixed-priority pick: lowest target code wins.
module pwt_arbiter
  import pwt_pkg::*;
(
  input  logic [NUM_TGT-1:0] ready,
  output logic               any,
  output logic [SEL_W-1:0]   pick
);

  always_comb begin
    any  = |ready;
    pick = '0;
    for (int i = NUM_TGT - 1; i >= 0; i--)
      if (ready[i]) pick = SEL_W'(i);
  end

endmodule

// File: rtl/pwt_launch.sv
// Request/acknowledge launcher toward the slow domain.
module pwt_launch
  import pwt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        any,
  input  logic [SEL_W-1:0]            pick,
  input  logic [NUM_TGT-1:0][DW-1:0]  word,
  input  logic                        ack,
  output logic                        req,
  output logic [SEL_W-1:0]            sel,
  output logic [DW-1:0]               data,
  output logic                        launch_go,
  output logic                        done_go
);

  logic [DW-1:0] pick_word;

  always_comb begin
    pick_word = '0;
    for (int i = 0; i < NUM_TGT; i++)
      if (pick == SEL_W'(i)) pick_word = word[i];
  end

  assign launch_go = !req && any;
  assign done_go   = req && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      sel  <= '0;
      data <= '0;
    end else if (launch_go) begin
      req  <= 1'b1;
      sel  <= pick;
      data <= pick_word;
    end else if (done_go) begin
      req  <= 1'b0;
    end
  end

endmodule

// File: rtl/posted_write_tracker.sv
module posted_write_tracker
  import pwt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_refused,
  output logic [15:0]       pend_status,
  output logic              xfer_req,
  output logic [2:0]        xfer_sel,
  output logic [DW-1:0]     xfer_data,
  input  logic              xfer_ack
);

  logic [NUM_TGT-1:0]         pend;
  logic [NUM_TGT-1:0]         ready;
  logic [NUM_TGT-1:0][DW-1:0] word;
  logic                       any;
  logic [SEL_W-1:0]           pick;
  logic                       launch_go;
  logic                       done_go;

  pwt_intake #(.DW(DW)) u_intake (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .launch_go  (launch_go),
    .launch_sel (pick),
    .done_go    (done_go),
    .done_sel   (xfer_sel),
    .pend       (pend),
    .ready      (ready),
    .word       (word),
    .refused    (wr_refused)
  );

  pwt_arbiter u_arb (
    .ready (ready),
    .any   (any),
    .pick  (pick)
  );

  pwt_launch #(.DW(DW)) u_launch (
    .clk       (clk),
    .rst       (rst),
    .any       (any),
    .pick      (pick),
    .word      (word),
    .ack       (xfer_ack),
    .req       (xfer_req),
    .sel       (xfer_sel),
    .data      (xfer_data),
    .launch_go (launch_go),
    .done_go   (done_go)
  );

  always_comb begin
    pend_status = '0;
    pend_status[STAT_LSB +: NUM_TGT] = pend;
  end

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker
  import pwt_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic          wr_refused,
  input logic [15:0]   pend_status,
  input logic          xfer_req,
  input logic [2:0]    xfer_sel,
  input logic [DW-1:0] xfer_data,
  input logic          xfer_ack
);

  logic       pend_of_wsel;
  logic       pend_of_xsel;
  logic [2:0] wsel_q;
  logic       wsel_data;

  assign pend_of_wsel = pend_status[STAT_LSB + int'(wr_sel)];
  assign pend_of_xsel = pend_status[STAT_LSB + int'(xfer_sel)];
  assign wsel_data    = wr_sel >= 3'd1 && wr_sel <= 3'd4;

  always_ff @(posedge clk) wsel_q <= wr_sel;

  // R1: reserved bits stay low
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    pend_status[15:13] == 3'b000 && pend_status[7:0] == 8'h00);

  // R2: accepted data write raises its pending bit
  a_r2_pend_sets: assert property (@(posedge clk) disable iff (rst)
    wr_en && wsel_data && !pend_of_wsel |=> pend_status[STAT_LSB + int'(wsel_q)]);

  // R3: a refusal only follows a write to a busy data target
  a_r3_refuse_cause: assert property (@(posedge clk) disable iff (rst)
    wr_refused |-> $past(wr_en) && $past(wsel_data) && $past(pend_of_wsel));

  // R4: data target pending bit drops after its acknowledge
  a_r4_pend_clears: assert property (@(posedge clk) disable iff (rst)
    xfer_req && xfer_ack && xfer_sel != 3'd0 |=> !pend_of_xsel);

  // R5: clear writes are never refused
  a_r5_clear_accepted: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel == 3'd0 |=> !wr_refused);

  // R7: a data transfer never starts while clears wait
  a_r7_clear_first: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_req) && xfer_sel != 3'd0 |-> !$past(pend_status[STAT_LSB]));

  // R8: request held stable until acknowledged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_sel) && $stable(xfer_data));

  // R8: request drops after acknowledge
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    xfer_req && xfer_ack |=> !xfer_req);

endmodule

bind posted_write_tracker pwt_checker #(.DW(DW)) u_pwt_checker (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_refused  (wr_refused),
  .pend_status (pend_status),
  .xfer_req    (xfer_req),
  .xfer_sel    (xfer_sel),
  .xfer_data   (xfer_data),
  .xfer_ack    (xfer_ack)
);

// File: tb/posted_write_tracker_test.sv
module posted_write_tracker_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 16;

  typedef struct packed {
    logic [2:0]    sel;
    logic [DW-1:0] data;
  } xfer_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_refused;
  logic [15:0]   pend_status;
  logic          xfer_req;
  logic [2:0]    xfer_sel;
  logic [DW-1:0] xfer_data;
  logic          xfer_ack;
  logic          auto_ack = 1'b0;
  logic          man_ack = 1'b0;
  logic          ack_en = 1'b0;

  int nchk = 0;
  int nerr = 0;
  xfer_t exp_q[$];

  assign xfer_ack = auto_ack | man_ack;

  always #10 clk = ~clk;

  posted_write_tracker #(.DW(DW)) uut (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .wr_refused  (wr_refused),
    .pend_status (pend_status),
    .xfer_req    (xfer_req),
    .xfer_sel    (xfer_sel),
    .xfer_data   (xfer_data),
    .xfer_ack    (xfer_ack)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Scoreboard compare of one observed transfer.
  task automatic take(input logic [2:0] s, input logic [DW-1:0] d);
    xfer_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R8", "unexpected transfer", {13'd0, s}, 32'hFFFF_FFFF);
    end else begin
      e = exp_q.pop_front();
      check(s == e.sel, "R7", "transfer target order", {29'd0, s}, {29'd0, e.sel});
      check(d == e.data, "R2 R5", "transfer data", {16'd0, d}, {16'd0, e.data});
    end
  endtask

  // Slow-domain responder and monitor.
  always @(negedge clk) begin
    if (auto_ack) auto_ack = 1'b0;
    else if (ack_en && xfer_req && !rst) begin
      take(xfer_sel, xfer_data);
      auto_ack = 1'b1;
    end
  end

  task automatic post(input logic [2:0] s, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
  endtask

  task automatic push(input logic [2:0] s, input logic [DW-1:0] d);
    xfer_t e;
    e.sel = s; e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || xfer_req) && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(n < 300, "R8", "transfers drain", n, 300);
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(pend_status == 16'h0000, "R10", "status after reset", pend_status, 0);
    check(!xfer_req, "R10", "req after reset", xfer_req, 0);
    check(!wr_refused, "R10", "refused after reset", wr_refused, 0);

    // R2 R1: single count word posting
    post(3'd1, 16'h1234);
    push(3'd1, 16'h1234);
    check(pend_status == 16'h0200, "R1", "count0 bit position", pend_status, 16'h0200);
    check(!wr_refused, "R2", "first write accepted", wr_refused, 0);
    @(negedge clk);
    check(xfer_req && xfer_sel == 3'd1, "R8", "request raised", {28'd0, xfer_req, xfer_sel}, 32'h9);
    ack_en = 1'b1;
    drain();
    check(pend_status == 16'h0000, "R4", "count0 pending cleared", pend_status, 0);
    post(3'd1, 16'h5678);
    push(3'd1, 16'h5678);
    check(!wr_refused, "R4", "rewrite accepted after ack", wr_refused, 0);
    drain();

    // R4: exact clear cycle with manual acknowledge
    ack_en = 1'b0;
    post(3'd3, 16'hA0A0);
    push(3'd3, 16'hA0A0);
    @(negedge clk);
    check(pend_status == 16'h0800, "R1", "alarm0 bit position", pend_status, 16'h0800);
    man_ack = 1'b1;
    take(xfer_sel, xfer_data);
    @(negedge clk);
    man_ack = 1'b0;
    check(pend_status == 16'h0000, "R4", "pending low cycle after ack", pend_status, 0);
    check(!xfer_req, "R8", "req dropped after ack", xfer_req, 0);

    // R3 refusal, then R7 priority with every target pending, R5 merging
    post(3'd4, 16'h1111);
    push(3'd4, 16'h1111);
    post(3'd4, 16'h2222);
    check(wr_refused, "R3", "busy write refused", wr_refused, 1);
    @(negedge clk);
    check(!wr_refused, "R3", "refusal lasts one cycle", wr_refused, 0);
    check(pend_status == 16'h1000, "R1", "alarm1 bit position", pend_status, 16'h1000);
    post(3'd3, 16'h3333);
    post(3'd2, 16'h4444);
    post(3'd1, 16'h5555);
    post(3'd0, 16'h0003);
    check(!wr_refused, "R5", "clear accepted", wr_refused, 0);
    post(3'd0, 16'h0030);
    check(!wr_refused, "R5", "second clear accepted", wr_refused, 0);
    check(pend_status == 16'h1F00, "R1", "all pending bits", pend_status, 16'h1F00);
    push(3'd0, 16'h0033);
    push(3'd1, 16'h5555);
    push(3'd2, 16'h4444);
    push(3'd3, 16'h3333);
    ack_en = 1'b1;
    drain();
    check(pend_status == 16'h0000, "R7", "all served", pend_status, 0);

    // R6: clear written while an earlier clear is in flight
    ack_en = 1'b0;
    post(3'd0, 16'h0100);
    push(3'd0, 16'h0100);
    @(negedge clk);
    post(3'd0, 16'h0200);
    post(3'd0, 16'h0400);
    push(3'd0, 16'h0600);
    check(pend_status == 16'h0100, "R6", "clear pending while in flight", pend_status, 16'h0100);
    ack_en = 1'b1;
    drain();
    check(pend_status == 16'h0000, "R6", "both clears done", pend_status, 0);

    // R6: clear written in the acknowledge cycle
    ack_en = 1'b0;
    post(3'd0, 16'h0008);
    push(3'd0, 16'h0008);
    @(negedge clk);
    man_ack = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 16'h0800;
    take(xfer_sel, xfer_data);
    @(negedge clk);
    man_ack = 1'b0;
    wr_en = 1'b0; wr_data = '0;
    check(pend_status == 16'h0100, "R6", "ack-cycle clear kept pending", pend_status, 16'h0100);
    push(3'd0, 16'h0800);
    ack_en = 1'b1;
    drain();

    // R9: ignored writes
    ack_en = 1'b0;
    post(3'd0, 16'h0000);
    check(!wr_refused, "R9", "zero clear not refused", wr_refused, 0);
    post(3'd6, 16'hFFFF);
    post(3'd5, 16'hFFFF);
    check(!wr_refused, "R9", "unknown target not refused", wr_refused, 0);
    repeat (3) @(negedge clk);
    check(pend_status == 16'h0000, "R9", "no pending after ignored writes", pend_status, 0);
    check(!xfer_req, "R9", "no transfer after ignored writes", xfer_req, 0);
    check(exp_q.size() == 0, "R8", "scoreboard empty", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule